// File: doc/BRIEF.md
# Sensor Data-Ready Flag Aggregator

This block tracks a new-data flag for each of seven sensor channels and turns those flags into a single data-ready pin. A sampling strobe marks the moment the channel output registers take fresh sensor values, and it raises every flag. A host read of a channel lowers that channel's flag. The pin signals ready while at least one channel that the host has selected still holds unread data. The host therefore sees ready stay high until it has read every channel it enabled.

The pin has two control inputs. An output-enable input decides whether the ready state reaches the pin at all. A polarity input selects active-high or active-low signalling. In auto-streaming mode the host does not read channels one at a time. Per-channel reads have no effect on the flags, and a frame-start strobe clears all flags just before a frame goes out. The flag vector is also brought out so that the surrounding register logic can use it.

Top module: `sample_ready_agg`

## Requirements
- R1: A cycle with `sample_upd` high sets all seven bits of `new_flags` at the next clock edge.
- R2: Outside streaming mode, a cycle with `chan_rd[i]` high and `sample_upd` low clears `new_flags[i]` at the next edge and leaves the other flags as they are.
- R3: When `sample_upd` and a channel's read strobe arrive in the same cycle, that channel's flag ends up set.
- R4: Internal ready is the OR of `new_flags & chan_en`, where `chan_en[i]` enables channel i. The pin is registered, so it follows this value one clock later.
- R5: With `chan_en` all zero, the pin stays at its inactive level whatever the flags hold.
- R6: While any enabled channel's flag is still set, the pin stays at its active level. It returns to the inactive level only after the last enabled flag has been cleared.
- R7: With `pin_oe` low, the pin is driven to its inactive level, which is `pin_act_low`.
- R8: With `pin_act_low` at 0 the pin is active-high. With `pin_act_low` at 1 the active level is 0 and the inactive level is 1.
- R9: With `stream_mode` high, `chan_rd` has no effect on the flags, and a `frame_start` pulse without `sample_upd` clears all flags at the next edge.
- R10: A synchronous `rst` clears every flag and drives the pin to its inactive level.
- R11: Changing `chan_en` changes the pin at the next edge and does not alter `new_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_upd | input | 1 | Sampling cycle complete; channel registers refreshed |
| chan_rd | input | 7 | Per-channel host read strobes |
| stream_mode | input | 1 | Auto-streaming mode select |
| frame_start | input | 1 | Streaming frame about to be sent |
| chan_en | input | 7 | Per-channel enable mask for the ready OR |
| pin_oe | input | 1 | Drive the ready state onto the pin |
| pin_act_low | input | 1 | 1 selects active-low pin signalling |
| ready_pin | output | 1 | Registered data-ready pin |
| new_flags | output | 7 | Per-channel new-data flags |

## Verification
The bench drives a sample strobe and a read of the same channel in the same cycle. A design where the clear wins would drop that channel's flag and lose a fresh sample. It reads the enabled channels one at a time and checks that the pin holds until the last one has been read. A design that takes the AND of the flags, or ignores the mask, would release the pin early or hold it forever. It also clears the mask, turns off the output enable and flips the polarity while flags are set, and checks the inactive level in each case. In streaming mode it checks that reads are ignored and that only the frame-start strobe clears the flags.

// File: rtl/srdy_pkg.sv
package srdy_pkg;
  parameter int unsigned CHANNELS = 7;

  typedef struct packed {
    logic out_en;
    logic act_low;
  } pin_cfg_t;
endpackage

// File: rtl/chan_flag_bank.sv
module chan_flag_bank #(
  parameter int unsigned NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [NCH-1:0] rd,
  input  logic           stream_mode,
  input  logic           stream_clr,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] clr_vec;

  // streaming mode replaces per-channel reads with one frame-wide clear
  assign clr_vec = stream_mode ? {NCH{stream_clr}} : rd;

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (upd)        flags[i] <= 1'b1;  // set has priority over clear
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end

  AST_UPD_SETS_ALL: assert property (@(posedge clk) disable iff (rst)
    upd |=> (&flags)); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!upd && !stream_mode) |=> ((flags & $past(rd)) == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (upd && (|rd)) |=> ((flags & $past(rd)) == $past(rd))); // R3
  AST_STREAM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stream_mode && stream_clr && !upd) |=> (flags == '0)); // R9
  AST_STREAM_IGNORES_RD: assert property (@(posedge clk) disable iff (rst)
    (stream_mode && !stream_clr && !upd) |=> $stable(flags)); // R9
endmodule

// File: rtl/ready_combine.sv
module ready_combine #(
  parameter int unsigned NCH = 7
) (
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] mask,
  output logic           ready
);
  logic [NCH-1:0] live;

  always_comb begin
    live  = flags & mask;
    ready = |live;
  end
endmodule

// File: rtl/pin_shaper.sv
module pin_shaper
  import srdy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ready,
  input  pin_cfg_t cfg,
  output logic     pin
);
  logic level;

  always_comb begin
    if (cfg.out_en) level = ready ^ cfg.act_low;
    else            level = cfg.act_low;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= cfg.act_low;
    else     pin <= level;
  end

  AST_PIN_OFF_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !cfg.out_en |=> (pin == $past(cfg.act_low))); // R7
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (cfg.out_en && ready) |=> (pin == !$past(cfg.act_low))); // R8
endmodule

// File: rtl/sample_ready_agg.sv
module sample_ready_agg
  import srdy_pkg::*;
#(
  parameter int unsigned NCH = CHANNELS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sample_upd,
  input  logic [NCH-1:0] chan_rd,
  input  logic           stream_mode,
  input  logic           frame_start,
  input  logic [NCH-1:0] chan_en,
  input  logic           pin_oe,
  input  logic           pin_act_low,
  output logic           ready_pin,
  output logic [NCH-1:0] new_flags
);
  logic     ready_int;
  pin_cfg_t cfg;

  assign cfg.out_en  = pin_oe;
  assign cfg.act_low = pin_act_low;

  chan_flag_bank #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .upd(sample_upd), .rd(chan_rd),
    .stream_mode(stream_mode), .stream_clr(frame_start), .flags(new_flags)
  );

  ready_combine #(.NCH(NCH)) u_comb (
    .flags(new_flags), .mask(chan_en), .ready(ready_int)
  );

  pin_shaper u_pin (
    .clk(clk), .rst(rst), .ready(ready_int), .cfg(cfg), .pin(ready_pin)
  );

  AST_MASK_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (chan_en == '0) |=> (ready_pin == $past(pin_act_low))); // R5
  AST_HOLD_WHILE_UNREAD: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && ((new_flags & chan_en) != '0)) |=> (ready_pin != $past(pin_act_low))); // R6
  AST_MASK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!sample_upd && !frame_start && chan_rd == '0 && chan_en != $past(chan_en))
      |=> (new_flags == $past(new_flags))); // R11
endmodule

// File: tb/sample_ready_agg_tb.sv
module sample_ready_agg_tb_top;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst;
  logic           sample_upd;
  logic [NCH-1:0] chan_rd;
  logic           stream_mode;
  logic           frame_start;
  logic [NCH-1:0] chan_en;
  logic           pin_oe;
  logic           pin_act_low;
  logic           ready_pin;
  logic [NCH-1:0] new_flags;

  int checks   = 0;
  int failures = 0;
  logic [NCH-1:0] m_flags;
  logic           m_pin;

  always #5 clk = ~clk;

  sample_ready_agg dut_i (
    .clk(clk), .rst(rst), .sample_upd(sample_upd), .chan_rd(chan_rd),
    .stream_mode(stream_mode), .frame_start(frame_start), .chan_en(chan_en),
    .pin_oe(pin_oe), .pin_act_low(pin_act_low),
    .ready_pin(ready_pin), .new_flags(new_flags)
  );

  function automatic logic [NCH-1:0] f_flags(input logic [NCH-1:0] f,
      input logic up, input logic [NCH-1:0] rd, input logic sm, input logic fs);
    logic [NCH-1:0] clr;
    clr = sm ? {NCH{fs}} : rd;
    if (up) return '1;
    return f & ~clr;
  endfunction

  function automatic logic f_pin(input logic [NCH-1:0] f,
      input logic [NCH-1:0] en, input logic oe, input logic al);
    if (!oe) return al;
    return ((f & en) != '0) ? !al : al;
  endfunction

  // one clock: compute expectation from current inputs, then sample 1 ns after the edge
  task automatic step(input string tag);
    logic [NCH-1:0] nf;
    logic np;
    if (rst) begin
      nf = '0;
      np = pin_act_low;
    end else begin
      nf = f_flags(m_flags, sample_upd, chan_rd, stream_mode, frame_start);
      np = f_pin(m_flags, chan_en, pin_oe, pin_act_low);
    end
    @(posedge clk);
    #1;
    m_flags = nf;
    m_pin   = np;
    checks++;
    if (new_flags !== m_flags) begin
      failures++;
      $display("FAIL %s flags actual=%b expected=%b", tag, new_flags, m_flags);
    end
    checks++;
    if (ready_pin !== m_pin) begin
      failures++;
      $display("FAIL %s pin actual=%b expected=%b", tag, ready_pin, m_pin);
    end
  endtask

  task automatic idle();
    sample_upd  = 1'b0;
    chan_rd     = '0;
    frame_start = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_flags = '0;
    m_pin   = 1'b0;
    rst = 1'b1; idle(); stream_mode = 1'b0;
    chan_en = '1; pin_oe = 1'b1; pin_act_low = 1'b0;
    #1;
    step("R10"); step("R10");
    rst = 1'b0;
    step("R10");

    sample_upd = 1'b1; step("R1");
    idle(); step("R4");
    for (int i = 0; i < NCH - 1; i++) begin
      chan_rd = NCH'(1) << i; step("R6");
    end
    chan_rd = NCH'(1) << (NCH - 1); step("R2");
    idle(); step("R6");

    sample_upd = 1'b1; step("R1");
    sample_upd = 1'b1; chan_rd = 7'b0001000; step("R3");
    idle(); chan_en = '0; step("R5");
    step("R11");
    chan_en = 7'b0100000; step("R11");
    pin_act_low = 1'b1; step("R8");
    step("R8");
    pin_oe = 1'b0; step("R7");
    step("R7");
    pin_oe = 1'b1; pin_act_low = 1'b0; step("R4");

    stream_mode = 1'b1; chan_rd = '1; step("R9");
    chan_rd = '0; step("R9");
    frame_start = 1'b1; step("R9");
    idle(); step("R9");
    stream_mode = 1'b0;
    rst = 1'b1; sample_upd = 1'b1; step("R10");
    rst = 1'b0; idle(); step("R10");

    for (int n = 0; n < 3000; n++) begin
      sample_upd  = ($urandom_range(0, 9) == 0);
      chan_rd     = ($urandom_range(0, 2) == 0) ? NCH'($urandom) : '0;
      frame_start = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 49) == 0) stream_mode = ~stream_mode;
      if ($urandom_range(0, 19) == 0) chan_en = NCH'($urandom);
      if ($urandom_range(0, 39) == 0) pin_oe = ~pin_oe;
      if ($urandom_range(0, 39) == 0) pin_act_low = ~pin_act_low;
      rst = ($urandom_range(0, 499) == 0);
      step("R4");
    end
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule